// File: doc/BRIEF.md
# Remote Terminal Host Word-Transfer Handshake

This block sits between the message sequencer of a serial-bus remote terminal and the host subsystem's external RAM. For every data word of a message it runs a three-step handshake with the host: it raises a request, waits for the host's grant, and then drives an acknowledge together with a RAM data strobe for one cycle. While the strobe is high, a read/write direction line tells the RAM whether the word is read out for transmission or written in from reception.

At the start of each message the sequencer pulses a start input. The block then latches the command word and clears a 5-bit word counter. The latched command and the counter together serve as the RAM address, and the counter advances after every completed word. A grant that does not arrive within a programmable number of cycles abandons the transfer and latches an active-low handshake-failure flag until the next message start.

While the host signals busy, the block raises no requests for data to transmit. Write data leaves the block on a separate bus with an output enable for the external tri-state pad; the enable is asserted only when the buffer-enable input allows it. At the end of a receive message that passed validation and carried the commanded number of words, a good-block pulse is issued.

Top module: `rt_host_xfer`

## Requirements
- R1: After reset, dt_req_o, dt_ack_o, strobe_o, ram_wdata_oe_o, core_rdata_vld_o and good_blk_o are 0, hs_fail_n_o is 1 and word_cnt_o is 0.
- R2: A word_req_i pulse while in_cmd_i is 1 and no transfer is in progress raises dt_req_o in the following cycle. A word_req_i pulse while in_cmd_i is 0 is ignored, and dt_req_o stays 0.
- R3: When dt_grant_i is 1 while dt_req_o is 1, the next cycle has dt_req_o at 0 and dt_ack_o and strobe_o at 1. Acknowledge and strobe last exactly one cycle.
- R4: rd_wr_o equals bit 10 (the transmit/receive bit) of the latched command word. A value of 1 means transmit, where the block reads RAM; a value of 0 means receive, where the block writes RAM.
- R5: A msg_start_i pulse latches cmd_word_i onto cmd_addr_o and clears word_cnt_o to 0. word_cnt_o rises by one, modulo 32, in the cycle after each acknowledge cycle.
- R6: If no grant arrives during TIMEOUT consecutive cycles of an uninhibited request, dt_req_o drops and hs_fail_n_o goes to 0 in the same cycle, and word_cnt_o does not advance. hs_fail_n_o stays 0 until the next msg_start_i.
- R7: While host_busy_i is 1 and the command is a transmit, dt_req_o is held at 0 and the timeout window is frozen. After busy drops, the request rises and the full TIMEOUT window applies.
- R8: ram_wdata_oe_o is 1 only in an acknowledge cycle of a receive command with buf_en_i at 1. At that point ram_wdata_o carries the core_wdata_i value captured with the word_req_i pulse.
- R9: For a transmit command, the ram_rdata_i value present in the acknowledge cycle appears on core_rdata_o with core_rdata_vld_o at 1 for one cycle, in the cycle that follows.
- R10: good_blk_o pulses for one cycle, in the cycle after msg_done_i, only if all of the following hold: msg_ok_i is 1, the command is a receive, hs_fail_n_o is 1, and the number of words acknowledged equals the word-count field (bits 4:0, where 0 means 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_start_i | input | 1 | Message start pulse: latches command, clears counter and failure flag |
| in_cmd_i | input | 1 | High while a command is being processed |
| cmd_word_i | input | 16 | Command word, sampled on msg_start_i |
| word_req_i | input | 1 | Sequencer asks for one word transfer |
| core_wdata_i | input | 16 | Received word to be written to RAM, sampled with word_req_i |
| core_rdata_o | output | 16 | Word read from RAM for transmission |
| core_rdata_vld_o | output | 1 | core_rdata_o updated this cycle |
| msg_done_i | input | 1 | End-of-message pulse |
| msg_ok_i | input | 1 | Message passed validation, qualified by msg_done_i |
| host_busy_i | input | 1 | Host busy: inhibits transmit data requests |
| buf_en_i | input | 1 | Permits driving the external data bus |
| dt_req_o | output | 1 | Transfer request to host |
| dt_grant_i | input | 1 | Host grant |
| dt_ack_o | output | 1 | Transfer acknowledge |
| strobe_o | output | 1 | RAM data strobe |
| rd_wr_o | output | 1 | 1 = read RAM (transmit), 0 = write RAM (receive) |
| cmd_addr_o | output | 16 | Latched command word, upper RAM address |
| word_cnt_o | output | 5 | Word counter, lower RAM address |
| ram_wdata_o | output | 16 | Write data toward RAM |
| ram_wdata_oe_o | output | 1 | Output enable for the external data pad |
| ram_rdata_i | input | 16 | Read data from RAM |
| hs_fail_n_o | output | 1 | Active-low latched handshake failure |
| good_blk_o | output | 1 | Good block received pulse |

## Verification
Inputs change on falling edges and outputs are sampled on the next falling edge. Each registered result is therefore checked exactly one cycle after the edge that should produce it. The checked results are: request after word_req_i, acknowledge after grant, counter and read data after the acknowledge, and good block after msg_done_i. The timeout is checked by counting falling edges. The request must still be high on the TIMEOUT-th sample after word_req_i, and the request must be low and the flag set on the sample after that. In the busy case the count restarts when busy falls, and a grant on the last cycle of the window must still be acknowledged.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned TR_BIT = 10;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/rtx_rst_sync.sv
module rtx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rtx_hs_fsm.sv
module rtx_hs_fsm
  import rtx_pkg::*;
#(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_start_i,
  input  logic in_cmd_i,
  input  logic word_req_i,
  input  logic host_busy_i,
  input  logic tx_i,
  input  logic grant_i,
  output logic accept_o,
  output logic req_o,
  output logic ack_o,
  output logic fail_n_o
);
  localparam int unsigned TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

  hs_state_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic fail_q, fail_d;
  logic inhibit;

  assign inhibit  = host_busy_i & tx_i;
  assign accept_o = (st_q == HS_IDLE) & word_req_i & in_cmd_i & ~msg_start_i;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    fail_d = fail_q;
    if (msg_start_i) begin
      st_d   = HS_IDLE;
      tmr_d  = '0;
      fail_d = 1'b0;
    end else begin
      unique case (st_q)
        HS_IDLE: begin
          if (accept_o) begin
            st_d  = HS_REQ;
            tmr_d = '0;
          end
        end
        HS_REQ: begin
          if (inhibit) begin
            tmr_d = tmr_q;
          end else if (grant_i) begin
            st_d = HS_ACK;
          end else if (tmr_q == T_LAST) begin
            st_d   = HS_IDLE;
            fail_d = 1'b1;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        HS_ACK:  st_d = HS_IDLE;
        default: st_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      tmr_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      fail_q <= fail_d;
    end
  end

  assign req_o    = (st_q == HS_REQ) & ~inhibit;
  assign ack_o    = (st_q == HS_ACK);
  assign fail_n_o = ~fail_q;
endmodule

// File: rtl/rtx_msg_ctx.sv
module rtx_msg_ctx
  import rtx_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic              ack_i,
  input  logic              msg_done_i,
  input  logic              msg_ok_i,
  input  logic              fail_n_i,
  output logic [WORD_W-1:0] cmd_q_o,
  output logic [CW-1:0]     cnt_o,
  output logic              tx_o,
  output logic              good_o
);
  localparam int unsigned NW = CW + 1;

  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic [NW-1:0]     cnt_q, cnt_d;
  logic              good_q, good_d;
  logic [NW-1:0]     exp_words;
  logic              cmd_en, cnt_en;

  assign exp_words = (cmd_q[CW-1:0] == '0) ? NW'(1 << CW) : {1'b0, cmd_q[CW-1:0]};

  assign cmd_en = msg_start_i;
  assign cnt_en = msg_start_i | ack_i;

  always_comb begin
    cmd_d  = cmd_word_i;
    cnt_d  = msg_start_i ? '0 : cnt_q + 1'b1;
    good_d = msg_done_i & msg_ok_i & ~cmd_q[TR_BIT] & fail_n_i & (cnt_q == exp_words)
             & ~msg_start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      if (cnt_en) cnt_q <= cnt_d;
      good_q <= good_d;
    end
  end

  assign cmd_q_o = cmd_q;
  assign cnt_o   = cnt_q[CW-1:0];
  assign tx_o    = cmd_q[TR_BIT];
  assign good_o  = good_q;
endmodule

// File: rtl/rtx_data_path.sv
module rtx_data_path
  import rtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              ack_i,
  input  logic              tx_i,
  input  logic              buf_en_i,
  input  logic [WORD_W-1:0] core_wdata_i,
  input  logic [WORD_W-1:0] ram_rdata_i,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic              ram_wdata_oe_o,
  output logic [WORD_W-1:0] core_rdata_o,
  output logic              core_rdata_vld_o
);
  logic [WORD_W-1:0] wd_q, rd_q;
  logic              vld_q, vld_d;
  logic              wd_en, rd_en;

  assign wd_en = accept_i;
  assign rd_en = ack_i & tx_i;
  assign vld_d = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= '0;
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wd_en) wd_q <= core_wdata_i;
      if (rd_en) rd_q <= ram_rdata_i;
      vld_q <= vld_d;
    end
  end

  assign ram_wdata_o      = wd_q;
  assign ram_wdata_oe_o   = ack_i & ~tx_i & buf_en_i;
  assign core_rdata_o     = rd_q;
  assign core_rdata_vld_o = vld_q;
endmodule

// File: rtl/rt_host_xfer.sv
module rt_host_xfer
  import rtx_pkg::*;
#(
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned CW      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start_i,
  input  logic              in_cmd_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic              word_req_i,
  input  logic [WORD_W-1:0] core_wdata_i,
  output logic [WORD_W-1:0] core_rdata_o,
  output logic              core_rdata_vld_o,
  input  logic              msg_done_i,
  input  logic              msg_ok_i,
  input  logic              host_busy_i,
  input  logic              buf_en_i,
  output logic              dt_req_o,
  input  logic              dt_grant_i,
  output logic              dt_ack_o,
  output logic              strobe_o,
  output logic              rd_wr_o,
  output logic [WORD_W-1:0] cmd_addr_o,
  output logic [CW-1:0]     word_cnt_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic              ram_wdata_oe_o,
  input  logic [WORD_W-1:0] ram_rdata_i,
  output logic              hs_fail_n_o,
  output logic              good_blk_o
);
  logic rst_sync_n;
  logic accept, ack, tx, fail_n;

  rtx_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rtx_hs_fsm #(.TIMEOUT(TIMEOUT)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .msg_start_i (msg_start_i),
    .in_cmd_i    (in_cmd_i),
    .word_req_i  (word_req_i),
    .host_busy_i (host_busy_i),
    .tx_i        (tx),
    .grant_i     (dt_grant_i),
    .accept_o    (accept),
    .req_o       (dt_req_o),
    .ack_o       (ack),
    .fail_n_o    (fail_n)
  );

  rtx_msg_ctx #(.CW(CW)) i_ctx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .msg_start_i (msg_start_i),
    .cmd_word_i  (cmd_word_i),
    .ack_i       (ack),
    .msg_done_i  (msg_done_i),
    .msg_ok_i    (msg_ok_i),
    .fail_n_i    (fail_n),
    .cmd_q_o     (cmd_addr_o),
    .cnt_o       (word_cnt_o),
    .tx_o        (tx),
    .good_o      (good_blk_o)
  );

  rtx_data_path i_dp (
    .clk              (clk),
    .rst_n            (rst_sync_n),
    .accept_i         (accept),
    .ack_i            (ack),
    .tx_i             (tx),
    .buf_en_i         (buf_en_i),
    .core_wdata_i     (core_wdata_i),
    .ram_rdata_i      (ram_rdata_i),
    .ram_wdata_o      (ram_wdata_o),
    .ram_wdata_oe_o   (ram_wdata_oe_o),
    .core_rdata_o     (core_rdata_o),
    .core_rdata_vld_o (core_rdata_vld_o)
  );

  assign dt_ack_o    = ack;
  assign strobe_o    = ack;
  assign rd_wr_o     = tx;
  assign hs_fail_n_o = fail_n;
endmodule

// File: rtl/rtx_checker.sv
module rtx_checker #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_start_i,
  input logic          msg_done_i,
  input logic          host_busy_i,
  input logic          buf_en_i,
  input logic          dt_req_o,
  input logic          dt_grant_i,
  input logic          dt_ack_o,
  input logic          rd_wr_o,
  input logic [CW-1:0] word_cnt_o,
  input logic          ram_wdata_oe_o,
  input logic          hs_fail_n_o,
  input logic          good_blk_o
);
  // R3: a granted request is acknowledged in the next cycle
  p_ack_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_req_o && dt_grant_i && !msg_start_i) |=> dt_ack_o);

  // R3: acknowledge is a single-cycle pulse
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dt_ack_o |=> !dt_ack_o);

  // R3: request and acknowledge never overlap
  p_req_ack_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dt_req_o && dt_ack_o));

  // R5: counter steps by one after an acknowledge
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_ack_o && !msg_start_i) |=> (word_cnt_o == CW'($past(word_cnt_o) + 1'b1)));

  // R5: counter clears at message start
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start_i |=> (word_cnt_o == '0));

  // R6: failure flag holds until message start
  p_fail_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_fail_n_o && !msg_start_i) |=> !hs_fail_n_o);

  // R7: no request while busy on a transmit command
  p_busy_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy_i && rd_wr_o) |-> !dt_req_o);

  // R8: write pad enable only in a permitted receive acknowledge
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wdata_oe_o |-> (buf_en_i && dt_ack_o && !rd_wr_o));

  // R10: good block only follows an end-of-message pulse
  p_good_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    good_blk_o |-> $past(msg_done_i));
endmodule

bind rt_host_xfer rtx_checker #(.CW(CW)) i_rtx_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .msg_start_i    (msg_start_i),
  .msg_done_i     (msg_done_i),
  .host_busy_i    (host_busy_i),
  .buf_en_i       (buf_en_i),
  .dt_req_o       (dt_req_o),
  .dt_grant_i     (dt_grant_i),
  .dt_ack_o       (dt_ack_o),
  .rd_wr_o        (rd_wr_o),
  .word_cnt_o     (word_cnt_o),
  .ram_wdata_oe_o (ram_wdata_oe_o),
  .hs_fail_n_o    (hs_fail_n_o),
  .good_blk_o     (good_blk_o)
);

// File: tb/test_rt_host_xfer.sv
module test_rt_host_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int TO         = 16;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_start = 1'b0, in_cmd = 1'b0, word_req = 1'b0;
  logic [15:0] cmd_word = '0, core_wdata = '0;
  logic        msg_done = 1'b0, msg_ok = 1'b0, busy = 1'b0, buf_en = 1'b1, grant = 1'b0;
  logic [15:0] core_rdata, cmd_addr, ram_wdata, ram_rdata;
  logic        core_vld, req, ack, strobe, rd_wr, oe, fail_n, good;
  logic [4:0]  cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ram_fn(logic [15:0] c, int w);
    return c ^ (16'(w) * 16'h0101) ^ 16'h5A00;
  endfunction

  assign ram_rdata = ram_fn(cmd_addr, int'(cnt));

  rt_host_xfer #(.TIMEOUT(TO), .CW(5)) i_rt_host_xfer (
    .clk(clk), .rst_n(rst_n), .msg_start_i(msg_start), .in_cmd_i(in_cmd),
    .cmd_word_i(cmd_word), .word_req_i(word_req), .core_wdata_i(core_wdata),
    .core_rdata_o(core_rdata), .core_rdata_vld_o(core_vld), .msg_done_i(msg_done),
    .msg_ok_i(msg_ok), .host_busy_i(busy), .buf_en_i(buf_en), .dt_req_o(req),
    .dt_grant_i(grant), .dt_ack_o(ack), .strobe_o(strobe), .rd_wr_o(rd_wr),
    .cmd_addr_o(cmd_addr), .word_cnt_o(cnt), .ram_wdata_o(ram_wdata),
    .ram_wdata_oe_o(oe), .ram_rdata_i(ram_rdata), .hs_fail_n_o(fail_n),
    .good_blk_o(good)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic start_msg(input logic [15:0] c);
    cmd_word = c; msg_start = 1'b1; in_cmd = 1'b1;
    @(negedge clk); msg_start = 1'b0;
    chk(cnt == 5'd0, "R5 cnt clear", 32'(cnt), 0);
    chk(cmd_addr == c, "R5 cmd latch", 32'(cmd_addr), 32'(c));
    chk(fail_n == 1'b1, "R6 flag clear on start", 32'(fail_n), 1);
    chk(rd_wr == c[10], "R4 direction", 32'(rd_wr), 32'(c[10]));
  endtask

  task automatic end_msg(input bit ok, input bit exp_good);
    msg_done = 1'b1; msg_ok = ok;
    @(negedge clk); msg_done = 1'b0; msg_ok = 1'b0;
    chk(good == exp_good, "R10 good block", 32'(good), 32'(exp_good));
    @(negedge clk);
    chk(good == 1'b0, "R10 good single pulse", 32'(good), 0);
  endtask

  task automatic xfer(input logic [15:0] c, input int w, input logic [15:0] wd, input int dly);
    bit tx;
    tx = c[10];
    word_req = 1'b1; core_wdata = wd;
    @(negedge clk); word_req = 1'b0; core_wdata = 16'hDEAD;
    chk(req == 1'b1, "R2 request raised", 32'(req), 1);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(req == 1'b1, "R2 request held", 32'(req), 1);
    end
    grant = 1'b1;
    @(negedge clk); grant = 1'b0;
    chk(ack && strobe && !req, "R3 ack strobe", {29'd0, ack, strobe, req}, 32'b110);
    chk(rd_wr == tx, "R4 direction in ack", 32'(rd_wr), 32'(tx));
    chk(oe == (!tx && buf_en), "R8 pad enable", 32'(oe), 32'(!tx && buf_en));
    if (!tx) chk(ram_wdata == wd, "R8 write data", 32'(ram_wdata), 32'(wd));
    @(negedge clk);
    chk(!ack && !strobe, "R3 ack one cycle", {30'd0, ack, strobe}, 0);
    chk(cnt == 5'((w + 1) % 32), "R5 counter step", 32'(cnt), 32'((w + 1) % 32));
    chk(core_vld == tx, "R9 read valid", 32'(core_vld), 32'(tx));
    if (tx) chk(core_rdata == ram_fn(c, w), "R9 read data", 32'(core_rdata), 32'(ram_fn(c, w)));
    @(negedge clk);
    chk(core_vld == 1'b0, "R9 valid single", 32'(core_vld), 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!req && !ack && !strobe && !oe && !core_vld && !good, "R1 outputs idle",
        {26'd0, req, ack, strobe, oe, core_vld, good}, 0);
    chk(fail_n == 1'b1, "R1 flag inactive", 32'(fail_n), 1);
    chk(cnt == 5'd0, "R1 counter zero", 32'(cnt), 0);

    // R2: request ignored outside a command
    in_cmd = 1'b0; word_req = 1'b1;
    @(negedge clk); word_req = 1'b0;
    chk(req == 1'b0, "R2 ignored without in_cmd", 32'(req), 0);
    @(negedge clk);
    chk(req == 1'b0, "R2 still idle", 32'(req), 0);

    // Sweep all word counts, alternating direction, varied grant delay
    for (int k = 0; k < 32; k++) begin
      c = {5'(k + 1), k[0], 5'(k + 3), 5'(k)};
      n = (k == 0) ? 32 : k;
      start_msg(c);
      for (int w = 0; w < n; w++)
        xfer(c, w, 16'(w * 257) ^ 16'(k), (w + k) % 4);
      end_msg(1'b1, !c[10]);
    end

    // R10: short receive message and failed validation
    c = {5'd3, 1'b0, 5'd2, 5'd4};
    start_msg(c);
    for (int w = 0; w < 3; w++) xfer(c, w, 16'h1000 + 16'(w), 0);
    end_msg(1'b1, 1'b0);
    start_msg(c);
    for (int w = 0; w < 4; w++) xfer(c, w, 16'h2000 + 16'(w), 1);
    end_msg(1'b0, 1'b0);

    // R8: buffer enable low keeps pad disabled
    buf_en = 1'b0;
    c = {5'd7, 1'b0, 5'd1, 5'd1};
    start_msg(c);
    xfer(c, 0, 16'hBEEF, 2);
    end_msg(1'b1, 1'b1);
    buf_en = 1'b1;

    // R6: grant timeout
    c = {5'd9, 1'b0, 5'd5, 5'd1};
    start_msg(c);
    word_req = 1'b1;
    @(negedge clk); word_req = 1'b0;
    chk(req == 1'b1, "R6 request up", 32'(req), 1);
    for (int d = 0; d < TO - 1; d++) begin
      @(negedge clk);
      chk(req && fail_n, "R6 window open", {30'd0, req, fail_n}, 3);
    end
    @(negedge clk);
    chk(!req && !fail_n, "R6 timeout flag", {30'd0, req, fail_n}, 0);
    chk(cnt == 5'd0, "R6 counter unchanged", 32'(cnt), 0);
    repeat (5) @(negedge clk);
    chk(fail_n == 1'b0, "R6 flag latched", 32'(fail_n), 0);
    end_msg(1'b1, 1'b0);
    start_msg(c);

    // R7: busy inhibits transmit requests and freezes the window
    c = {5'd4, 1'b1, 5'd6, 5'd1};
    start_msg(c);
    busy = 1'b1; word_req = 1'b1;
    @(negedge clk); word_req = 1'b0;
    for (int d = 0; d < 2 * TO; d++) begin
      chk(!req && fail_n, "R7 inhibited", {30'd0, req, fail_n}, 1);
      @(negedge clk);
    end
    busy = 1'b0;
    for (int d = 0; d < TO - 1; d++) begin
      @(negedge clk);
      chk(req && fail_n, "R7 fresh window", {30'd0, req, fail_n}, 3);
    end
    grant = 1'b1;
    @(negedge clk); grant = 1'b0;
    chk(ack == 1'b1 && fail_n, "R7 late grant acked", {30'd0, ack, fail_n}, 3);
    @(negedge clk);
    chk(cnt == 5'd1 && core_vld, "R7 transfer completed", {26'd0, core_vld, cnt}, 32'h21);
    chk(core_rdata == ram_fn(c, 0), "R9 read after busy", 32'(core_rdata), 32'(ram_fn(c, 0)));
    end_msg(1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule